// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares a reference pulse stream with a divided feedback pulse stream and turns the timing difference between their rising edges into charge-pump drive. A rising edge on either input sets a flag for that input. The flag stays set until the other input also shows an edge. When both flags are set, both clear on the next clock. A reference edge that arrives first therefore produces a reference-leading pulse whose width follows the phase error. A feedback edge that arrives first produces a feedback-leading pulse in the same way. If one input shows a second edge before the other input shows any edge, its flag simply stays set. This is what lets the detector tell a frequency error from a phase error.

The analog charge pump is represented by two drive enables, source and sink. When both enables are low, the pump output is high impedance. A polarity input swaps which error pulse drives source and which drives sink, so the block suits loops where the oscillator gain is positive and loops where it is negative. The two error pulses are also available as outputs of their own.

A lock flag goes high after a parameterised number of consecutive reference edges in which no error pulse lasted longer than one clock. Any longer error pulse drops the flag at once.

Top module: `phase_freq_detector`

## Requirements
- R1: While reset is high, and in the first cycle after it, both error pulses, both drive enables and the lock flag are low, so the pump output is high impedance.
- R2: A rising edge on the reference input, sampled at a clock edge, raises the reference-leading output from that clock edge onwards. The output stays high, including through further reference edges, until a feedback edge has also been seen.
- R3: A rising edge on the feedback input raises the feedback-leading output in the same way as R2, with the roles of the two inputs swapped.
- R4: When both error outputs are high, both are low after the next clock edge. Edges on the two inputs sampled at the same clock edge therefore make source and sink drive high together for exactly one clock.
- R5: With polarity 0, source equals the reference-leading output and sink equals the feedback-leading output. With polarity 1, the two are swapped. The polarity value sampled at a clock edge applies to the outputs registered at that same edge.
- R6: Whenever neither error output is high, source and sink are both low (high impedance). When the inputs are locked in phase and frequency, this holds for every cycle except the one-clock coincidence pulse.
- R7: The lock flag goes high at the clock edge that samples the 8th reference rising edge (parameter LOCK_PERIODS) counted since reset or since the last long error. It stays high while no long error occurs.
- R8: A long error is the same single error output being high alone for two consecutive cycles. A long error forces the lock flag low one clock later and restarts the count of R7. A reference edge sampled at that same clock edge is not counted.
- R9: Only a low-to-high transition counts as an edge. An input that stays high produces no further edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse_in | input | 1 | Reference pulse stream |
| fb_pulse_in | input | 1 | Divided feedback pulse stream |
| pol_swap | input | 1 | 0: reference lead drives source; 1: reference lead drives sink |
| ref_lead | output | 1 | Reference-leading error pulse |
| fb_lead | output | 1 | Feedback-leading error pulse |
| pump_src_en | output | 1 | Charge-pump source enable |
| pump_snk_en | output | 1 | Charge-pump sink enable |
| lock_flag | output | 1 | High while the loop is judged in lock |

## Verification
An input edge driven before a clock edge shows up on the error outputs and drive enables right after that edge. The lock flag moves on the same edge as the reference edge that completes the count. A long error moves it one edge later, because the check needs two cycles of flag history. The bench changes its inputs at the falling clock edge and compares at the following falling edge against a reference model. That model advances exactly one clock per stimulus step, so each output is compared in the cycle in which it becomes due. The directed phases add explicit checks at the coincidence pulse, at the cycle just after it, at the 7th and 8th locked period and after a long lead.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // One bit per compared input: reference and feedback.
  typedef struct packed {
    logic ref_f;
    logic fb_f;
  } pfd_pair_t;

  // The two charge-pump drive enables.
  typedef struct packed {
    logic src;
    logic snk;
  } pump_t;

  // Map the error pair onto the pump enables, honouring the polarity swap.
  function automatic pump_t steer(input pfd_pair_t err, input logic swap);
    pump_t p;
    if (swap) begin
      p.src = err.fb_f;
      p.snk = err.ref_f;
    end else begin
      p.src = err.ref_f;
      p.snk = err.fb_f;
    end
    return p;
  endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int WIDTH       = 2,
  parameter int SYNC_STAGES = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic sampled;
    logic prev_q;

    if (SYNC_STAGES == 0) begin : g_direct
      assign sampled = din[g];
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q <= '0;
        end else begin
          chain_q[0] <= din[g];
          for (int i = 1; i < SYNC_STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
          end
        end
      end
      assign sampled = chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= sampled;
    end

    // Only a low-to-high step counts; a held level is not an edge.
    assign rise[g] = sampled & ~prev_q;
  end

endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pfd_pair_t edge_in,
  input  logic      pol_swap,
  output pfd_pair_t flags_q,
  output pump_t     pump_q
);

  pfd_pair_t flags_nxt;
  logic      both_set;

  always_comb begin
    both_set = flags_q.ref_f & flags_q.fb_f;
    if (both_set) begin
      // Coincidence: clear both and keep only edges arriving right now.
      flags_nxt = edge_in;
    end else begin
      // A flag holds until the other side catches up (frequency discrimination).
      flags_nxt.ref_f = flags_q.ref_f | edge_in.ref_f;
      flags_nxt.fb_f  = flags_q.fb_f  | edge_in.fb_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      pump_q  <= '0;
    end else begin
      flags_q <= flags_nxt;
      pump_q  <= steer(flags_nxt, pol_swap);
    end
  end

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det
  import pfd_pkg::*;
#(
  parameter int LOCK_PERIODS = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  pfd_pair_t flags_q,
  input  logic      ref_edge,
  output logic      lock_q
);

  localparam int CW = (LOCK_PERIODS > 2) ? $clog2(LOCK_PERIODS) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_PERIODS - 1);

  logic [CW-1:0] period_cnt;
  logic          single_now;
  logic          single_q;
  logic          long_err;

  // Exactly one side flagged: an error pulse is in progress.
  assign single_now = flags_q.ref_f ^ flags_q.fb_f;
  assign long_err   = single_now & single_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      single_q   <= 1'b0;
      period_cnt <= '0;
      lock_q     <= 1'b0;
    end else begin
      single_q <= single_now;
      if (long_err) begin
        period_cnt <= '0;
        lock_q     <= 1'b0;
      end else if (ref_edge) begin
        if (period_cnt == LAST) lock_q <= 1'b1;
        else                    period_cnt <= period_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector
  import pfd_pkg::*;
#(
  parameter int LOCK_PERIODS = 8,
  parameter int SYNC_STAGES  = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse_in,
  input  logic fb_pulse_in,
  input  logic pol_swap,
  output logic ref_lead,
  output logic fb_lead,
  output logic pump_src_en,
  output logic pump_snk_en,
  output logic lock_flag
);

  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] rise_vec;
  pfd_pair_t         edge_pair;
  pfd_pair_t         flags;
  pump_t             pump;

  pfd_edge_det #(
    .WIDTH       (NUM_IN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({fb_pulse_in, ref_pulse_in}),
    .rise (rise_vec)
  );

  assign edge_pair.ref_f = rise_vec[0];
  assign edge_pair.fb_f  = rise_vec[1];

  pfd_flag_core u_core (
    .clk      (clk),
    .rst      (rst),
    .edge_in  (edge_pair),
    .pol_swap (pol_swap),
    .flags_q  (flags),
    .pump_q   (pump)
  );

  pfd_lock_det #(
    .LOCK_PERIODS (LOCK_PERIODS)
  ) u_lock (
    .clk      (clk),
    .rst      (rst),
    .flags_q  (flags),
    .ref_edge (edge_pair.ref_f),
    .lock_q   (lock_flag)
  );

  assign ref_lead    = flags.ref_f;
  assign fb_lead     = flags.fb_f;
  assign pump_src_en = pump.src;
  assign pump_snk_en = pump.snk;

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
  input logic clk,
  input logic rst,
  input logic pol_swap,
  input logic ref_lead,
  input logic fb_lead,
  input logic pump_src_en,
  input logic pump_snk_en,
  input logic lock_flag
);

  assert_ref_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (ref_lead && !fb_lead) |=> ref_lead);

  assert_fb_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (fb_lead && !ref_lead) |=> fb_lead);

  assert_coincidence_one_clock_R4: assert property (@(posedge clk) disable iff (rst)
    (ref_lead && fb_lead) |=> !(ref_lead && fb_lead));

  assert_polarity_map_R5: assert property (@(posedge clk) disable iff (rst)
    (pump_src_en == ($past(pol_swap) ? fb_lead : ref_lead)) &&
    (pump_snk_en == ($past(pol_swap) ? ref_lead : fb_lead)));

  assert_idle_high_z_R6: assert property (@(posedge clk) disable iff (rst)
    (!ref_lead && !fb_lead) |-> (!pump_src_en && !pump_snk_en));

  assert_long_error_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
    ((ref_lead ^ fb_lead) && $past(ref_lead ^ fb_lead)) |=> !lock_flag);

endmodule

bind phase_freq_detector pfd_checker u_pfd_checker (
  .clk         (clk),
  .rst         (rst),
  .pol_swap    (pol_swap),
  .ref_lead    (ref_lead),
  .fb_lead     (fb_lead),
  .pump_src_en (pump_src_en),
  .pump_snk_en (pump_snk_en),
  .lock_flag   (lock_flag)
);

// File: tb/phase_freq_detector_bench.sv
module phase_freq_detector_bench;

  localparam int LOCKN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic pol = 1'b0;
  logic ref_lead, fb_lead, src_en, snk_en, lock_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state (values visible on the outputs at the current negedge)
  logic m_prev_r = 0, m_prev_f = 0, m_rf = 0, m_ff = 0;
  logic m_src = 0, m_snk = 0, m_sp = 0, m_lock = 0;
  int   m_cnt = 0;

  always #5 clk = ~clk;

  phase_freq_detector u_phase_freq_detector (
    .clk(clk), .rst(rst), .ref_pulse_in(ref_in), .fb_pulse_in(fb_in),
    .pol_swap(pol), .ref_lead(ref_lead), .fb_lead(fb_lead),
    .pump_src_en(src_en), .pump_snk_en(snk_en), .lock_flag(lock_flag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 ref_lead", ref_lead, m_rf);
    chk("R3 fb_lead", fb_lead, m_ff);
    chk("R5 source", src_en, m_src);
    chk("R5 sink", snk_en, m_snk);
    chk("R7 lock", lock_flag, m_lock);
  endtask

  // Next-state model built from the requirements.
  task automatic model_advance(input logic r, input logic f, input logic p);
    logic rr, fr, nrf, nff, long_err;
    rr = r & ~m_prev_r;                 // R9
    fr = f & ~m_prev_f;
    if (m_rf && m_ff) begin nrf = rr; nff = fr; end   // R4
    else begin nrf = m_rf | rr; nff = m_ff | fr; end  // R2, R3
    long_err = (m_rf ^ m_ff) & m_sp;    // R8
    m_sp = m_rf ^ m_ff;
    if (long_err) begin m_cnt = 0; m_lock = 0; end
    else if (rr) begin
      if (m_cnt == LOCKN - 1) m_lock = 1;   // R7
      else m_cnt++;
    end
    m_src = p ? nff : nrf;              // R5
    m_snk = p ? nrf : nff;
    m_rf = nrf; m_ff = nff;
    m_prev_r = r; m_prev_f = f;
  endtask

  task automatic step(input logic r, input logic f, input logic p);
    compare_all();
    ref_in = r; fb_in = f; pol = p;
    model_advance(r, f, p);
    @(negedge clk);
  endtask

  // One period of length len with two-cycle pulses starting at r_off / f_off.
  task automatic period(input int r_off, input int f_off, input int len, input logic p);
    for (int c = 0; c < len; c++) begin
      step((c >= r_off && c < r_off + 2), (c >= f_off && c < f_off + 2), p);
      if (r_off == f_off && c == r_off) begin
        chk("R4 both drive on coincidence", src_en & snk_en, 1'b1);
      end
      if (r_off == f_off && c == r_off + 1) begin
        chk("R4 coincidence lasts one clock src", src_en, 1'b0);
        chk("R4 coincidence lasts one clock snk", snk_en, 1'b0);
      end
      if (r_off == f_off && c == len - 1) begin
        chk("R6 high impedance when in phase", src_en | snk_en, 1'b0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1c0d));
    repeat (3) @(negedge clk);
    chk("R1 reset ref_lead", ref_lead, 1'b0);
    chk("R1 reset fb_lead", fb_lead, 1'b0);
    chk("R1 reset source", src_en, 1'b0);
    chk("R1 reset sink", snk_en, 1'b0);
    chk("R1 reset lock", lock_flag, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", src_en | snk_en | lock_flag, 1'b0);

    // In-phase inputs: coincidence pulses and lock acquisition (R4, R6, R7)
    for (int k = 0; k < LOCKN - 1; k++) period(0, 0, 10, 1'b0);
    chk("R7 not locked after 7 periods", lock_flag, 1'b0);
    period(0, 0, 10, 1'b0);
    chk("R7 locked after 8 periods", lock_flag, 1'b1);
    period(0, 0, 10, 1'b1);
    chk("R7 lock held", lock_flag, 1'b1);

    // Reference leads by 3 clocks: long error drops lock (R8)
    period(0, 3, 10, 1'b0);
    chk("R8 lock cleared by long error", lock_flag, 1'b0);

    // Frequency discrimination: two reference edges before one feedback edge (R2, R9)
    for (int c = 0; c < 12; c++) begin
      step((c < 2) || (c == 4) || (c == 5), (c == 8) || (c == 9), 1'b0);
      if (c == 6) chk("R2 ref_lead held over second ref edge", ref_lead, 1'b1);
    end
    chk("R2 ref_lead cleared after feedback", ref_lead, 1'b0);

    // Feedback leads with swapped polarity (R3, R5)
    period(4, 0, 10, 1'b1);
    period(5, 0, 10, 1'b0);

    // Single-clock lead keeps lock counting (R7)
    for (int k = 0; k < LOCKN; k++) period(1, 0, 10, 1'b0);
    chk("R7 lock with one-clock lead", lock_flag, 1'b1);

    // Constrained random pulse streams
    for (int c = 0; c < 4000; c++) begin
      step(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 16) == 0 ? ~pol : pol);
    end
    for (int k = 0; k < 40; k++) begin
      period($urandom % 3, $urandom % 3, 6 + ($urandom % 6), $urandom % 2);
    end
    compare_all();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule